// File: doc/BRIEF.md
# Coherent 16-bit Byte-Access Timer

This block is a 16-bit up-counter that software reaches over an 8-bit register bus. Four addresses expose the counter's low byte, its high byte, a control register and an overflow flag. The control register holds a run bit, a source select, a prescale field and a mode bit that turns on buffered access. In buffered access the high-byte address no longer touches the live counter. It reaches a shadow byte instead. Reading the low byte snapshots the live high byte into that shadow. Writing the low byte loads the shadow into the live high byte. A 16-bit read or write therefore never tears across a carry out of the low byte.

Counting is driven either by every system clock cycle or by rising edges of an external tick input. The external tick passes through a two-flop synchroniser. It then goes to a two-state edge machine with states `EDGE_LOW` and `EDGE_HIGH`:
- The transition `EDGE_LOW -> EDGE_HIGH`, taken when the synchronised tick is high, is the cycle that emits one increment request.
- The transition `EDGE_HIGH -> EDGE_LOW`, taken when the synchronised tick is low, re-arms the machine.

The selected ticks pass through a power-of-two prescaler before they reach the counter. A carry out of 0xFFFF sets a sticky flag and emits a one-cycle pulse.

Register addresses: 0 = low byte, 1 = high byte, 2 = control, 3 = flag. The control register bits are:
- bit 0: run enable
- bit 1: buffered mode
- bit 2: source select (0 = system clock, 1 = external tick)
- bits 4:3: prescale select

The flag register reports the overflow flag in bit 0.

Top module: `tmr16_coherent`

## Requirements
- R1: After reset the low byte, high byte, control register, flag and shadow byte all read 0.
- R2: With control bit 1 clear, address 1 reads and writes the live high byte directly, and a read of address 0 leaves the shadow byte unchanged.
- R3: With control bit 1 set, a read of address 0 returns the live low byte and copies the live high byte into the shadow byte on the same clock edge. Address 1 then reads the shadow byte.
- R4: With control bit 1 set, a write to address 1 changes only the shadow byte, and the live high byte keeps its value.
- R5: With control bit 1 set, a write to address 0 loads the low byte from the bus and the high byte from the shadow byte on the same edge.
- R6: With control bits 4:3 = s and bit 0 set, the counter advances once per 2^s source ticks (divide by 1, 2, 4 or 8).
- R7: A write to address 0 resets the prescaler phase, and a write to address 1 leaves the phase unchanged.
- R8: With control bit 2 set, the counter's source is the external tick. After a two-flop synchroniser, each rising edge gives exactly one prescaler tick.
- R9: A carry from 0xFFFF to 0x0000 sets flag bit 0 and raises `ovf_pulse` for one cycle. Writing 0 to address 3 bit 0 clears the flag, and writing 1 leaves it unchanged.
- R10: A write to address 0 in a cycle that also carries an increment wins, and the byte written is the low byte held after that edge.
- R11: With control bit 0 clear and no bus write, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, which drives the low-byte snapshot |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| ext_tick | input | 1 | Asynchronous external count source |
| ovf_pulse | output | 1 | One-cycle pulse on a counter carry-out |

## Verification
The bench builds the block with its default byte width of 8 and a 2-bit prescale field. With these values all four divide ratios fit inside a 16-tick window, so each ratio is measured to an exact count. Because the counter is 16 bits, preloading 0xFFFE puts the carry-out only two ticks away. The narrow prescaler also lets a partial phase carry across a high-byte write and still show up in a single increment.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
    localparam int SEL_W = 2;

    typedef enum logic [1:0] {
        REG_LO   = 2'd0,
        REG_HI   = 2'd1,
        REG_CTRL = 2'd2,
        REG_FLAG = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [SEL_W-1:0] div_sel;
        logic             ext_src;
        logic             buffered;
        logic             run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr16_tick_sync.sv
module tmr16_tick_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    output logic rise
);
    typedef enum logic {EDGE_LOW = 1'b0, EDGE_HIGH = 1'b1} edge_state_e;

    logic        sync1, sync2;
    edge_state_e state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= ext_in;
            sync2 <= sync1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= EDGE_LOW;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            EDGE_LOW:  if (sync2)  state_nxt = EDGE_HIGH;
            EDGE_HIGH: if (!sync2) state_nxt = EDGE_LOW;
        endcase
    end

    always_comb begin
        rise = (state == EDGE_LOW) && sync2;
    end

    p_single_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/tmr16_prescaler.sv
module tmr16_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             tc
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] phase;
    logic [CNT_W-1:0] mask;
    logic             terminal;

    always_comb begin
        mask     = ~({CNT_W{1'b1}} << sel);
        terminal = &(phase | ~mask);
        tc       = tick && terminal;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       phase <= '0;
        else if (clear)   phase <= '0;
        else if (tick)    phase <= terminal ? '0 : phase + 1'b1;
    end

    p_clear_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (phase == '0));
endmodule

// File: rtl/tmr16_coherent.sv
module tmr16_coherent
    import tmr16_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              ext_tick,
    output logic              ovf_pulse
);
    localparam int CNT_W = 2 * BYTE_W;

    reg_addr_e         addr_q;
    ctrl_t             ctrl;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shadow;
    logic              ovf_flag;
    logic              wr_lo, wr_hi, wr_ctrl, wr_flag, rd_lo;
    logic              hi_direct_wr, ext_rise, src_tick, psc_tick, inc, wrap;

    always_comb begin
        addr_q       = reg_addr_e'(bus_addr);
        wr_lo        = bus_wr && (addr_q == REG_LO);
        wr_hi        = bus_wr && (addr_q == REG_HI);
        wr_ctrl      = bus_wr && (addr_q == REG_CTRL);
        wr_flag      = bus_wr && (addr_q == REG_FLAG);
        rd_lo        = bus_rd && (addr_q == REG_LO);
        hi_direct_wr = wr_hi && !ctrl.buffered;
        src_tick     = ctrl.ext_src ? ext_rise : 1'b1;
        psc_tick     = ctrl.run && src_tick;
        wrap         = inc && !wr_lo && !hi_direct_wr && (cnt == {CNT_W{1'b1}});
    end

    tmr16_tick_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .ext_in (ext_tick),
        .rise   (ext_rise)
    );

    tmr16_prescaler #(.SEL_W(SEL_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (wr_lo),
        .tick  (psc_tick),
        .sel   (ctrl.div_sel),
        .tc    (inc)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl <= '0;
        else if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wr_lo) begin
            cnt <= {(ctrl.buffered ? shadow : cnt[CNT_W-1:BYTE_W]), bus_wdata};
        end else if (hi_direct_wr) begin
            cnt <= {bus_wdata, cnt[BYTE_W-1:0]};
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (ctrl.buffered) begin
            if (wr_hi)      shadow <= bus_wdata;
            else if (rd_lo) shadow <= cnt[CNT_W-1:BYTE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_flag  <= 1'b0;
            ovf_pulse <= 1'b0;
        end else begin
            ovf_pulse <= wrap;
            if (wrap)                         ovf_flag <= 1'b1;
            else if (wr_flag && !bus_wdata[0]) ovf_flag <= 1'b0;
        end
    end

    always_comb begin
        unique case (addr_q)
            REG_LO:   bus_rdata = cnt[BYTE_W-1:0];
            REG_HI:   bus_rdata = ctrl.buffered ? shadow : cnt[CNT_W-1:BYTE_W];
            REG_CTRL: bus_rdata = BYTE_W'(ctrl);
            REG_FLAG: bus_rdata = BYTE_W'(ovf_flag);
        endcase
    end

    p_direct_no_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.buffered |=> $stable(shadow));
    p_lo_read_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.buffered && rd_lo && !bus_wr |=> shadow == $past(cnt[CNT_W-1:BYTE_W]));
    p_hi_write_shadow_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.buffered && wr_hi && !inc |=> cnt[CNT_W-1:BYTE_W] == $past(cnt[CNT_W-1:BYTE_W]));
    p_joint_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.buffered && wr_lo |=> cnt[CNT_W-1:BYTE_W] == $past(shadow));
    p_flag_with_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> ovf_flag);
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag && !(wr_flag && !bus_wdata[0]) |=> ovf_flag);
    p_lo_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> cnt[BYTE_W-1:0] == $past(bus_wdata));
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.run && !bus_wr |=> $stable(cnt));
endmodule

// File: tb/tmr16_coherent_tb_top.sv
`timescale 1ns/1ps
module tmr16_coherent_tb_top;
    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ext_tick = 1'b0;
    logic       ovf_pulse;

    exp_t q[$];
    int   checks = 0;
    int   fails = 0;
    int   ovf_seen = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    tmr16_coherent dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_tick  (ext_tick),
        .ovf_pulse (ovf_pulse)
    );

    // monitor: pops the scoreboard on every read strobe
    always @(negedge clk) begin
        if (rst_n && ovf_pulse) ovf_seen++;
        if (bus_rd) begin
            exp_t it;
            checks++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL scoreboard: read with no expectation, got %h expected none", bus_rdata);
            end else begin
                it = q.pop_front();
                if (bus_rdata !== it.exp) begin
                    fails++;
                    $display("FAIL %s: got %h expected %h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        exp_t it;
        it.exp = e; it.tag = tag;
        q.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input int act, input int e, input string tag);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, e);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        wait_cycles(1);

        // R1 reset state
        rd(2'd0, 8'h00, "R1 low");
        rd(2'd1, 8'h00, "R1 high");
        rd(2'd2, 8'h00, "R1 ctrl");
        rd(2'd3, 8'h00, "R1 flag");
        wr(2'd2, 8'h02);
        rd(2'd1, 8'h00, "R1 shadow");
        wr(2'd2, 8'h00);

        // R6 every divide ratio over 16 source ticks
        for (int s = 0; s < 4; s++) begin
            wr(2'd1, 8'h00);
            wr(2'd0, 8'h00);
            wr(2'd2, 8'((s << 3) | 1));
            wait_cycles(15);
            wr(2'd2, 8'h00);
            rd(2'd0, 8'(16 >> s), "R6 divide count");
        end

        // R7 high write keeps prescaler phase, low write clears it
        wr(2'd1, 8'h00); wr(2'd0, 8'h00);
        wr(2'd2, 8'h11); wait_cycles(1); wr(2'd2, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h11); wait_cycles(1); wr(2'd2, 8'h00);
        rd(2'd0, 8'h01, "R7 phase kept");
        wr(2'd0, 8'h40);
        wr(2'd2, 8'h11); wait_cycles(1); wr(2'd2, 8'h00);
        rd(2'd0, 8'h40, "R7 phase cleared");

        // R8 external edges, divide by 2
        wr(2'd1, 8'h00); wr(2'd0, 8'h00);
        wr(2'd2, 8'h0D);
        for (int p = 0; p < 6; p++) begin
            ext_tick = 1'b1; wait_cycles(3);
            ext_tick = 1'b0; wait_cycles(3);
        end
        wait_cycles(6);
        wr(2'd2, 8'h00);
        rd(2'd0, 8'h03, "R8 external edges");

        // R10 low write wins over same-cycle increment
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h55);
        rd(2'd0, 8'h55, "R10 written value held");
        wr(2'd2, 8'h00);

        // R2, R3, R4, R5 access modes
        wr(2'd1, 8'h12); wr(2'd0, 8'h34);
        rd(2'd1, 8'h12, "R2 direct high");
        wr(2'd2, 8'h02);
        rd(2'd0, 8'h34, "R3 live low");
        rd(2'd1, 8'h12, "R3 captured high");
        wr(2'd1, 8'hAB);
        rd(2'd1, 8'hAB, "R4 shadow written");
        rd(2'd0, 8'h34, "R4 low unchanged");
        rd(2'd1, 8'h12, "R4 live high kept");
        wr(2'd1, 8'hCD); wr(2'd0, 8'hEF);
        wr(2'd2, 8'h00);
        rd(2'd1, 8'hCD, "R5 joint high");
        rd(2'd0, 8'hEF, "R5 joint low");
        wr(2'd1, 8'h77);
        rd(2'd0, 8'hEF, "R2 direct low read");
        wr(2'd2, 8'h02);
        rd(2'd1, 8'hCD, "R2 shadow untouched");
        wr(2'd2, 8'h00);

        // R9 rollover, flag and pulse
        wr(2'd1, 8'hFF); wr(2'd0, 8'hFE);
        ovf_seen = 0;
        wr(2'd2, 8'h01); wait_cycles(1); wr(2'd2, 8'h00);
        wait_cycles(3);
        check(ovf_seen == 1, ovf_seen, 1, "R9 pulse count");
        rd(2'd3, 8'h01, "R9 flag set");
        rd(2'd0, 8'h00, "R9 low wrapped");
        rd(2'd1, 8'h00, "R9 high wrapped");
        wr(2'd3, 8'h01);
        rd(2'd3, 8'h01, "R9 write one ignored");
        wr(2'd3, 8'h00);
        rd(2'd3, 8'h00, "R9 flag cleared");

        // R11 hold while stopped
        wr(2'd0, 8'h21);
        wait_cycles(10);
        rd(2'd0, 8'h21, "R11 hold low");
        rd(2'd1, 8'h00, "R11 hold high");

        wait_cycles(2);
        if (q.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard: got %0d pending expected 0", q.size());
        end
        done = 1'b1;
        finish_run();
    end
endmodule